// File: doc/BRIEF.md
# Temperature-Proportional Fan PWM Controller

This block drives a cooling fan with a slow pulse-width modulated signal. Two digitized control codes (a primary sensor code and a secondary control code, each an unsigned fraction of full scale) are compared. The larger of the two sets the duty cycle through a linear window. The duty cycle is produced by comparing a stored level against a sawtooth counter that advances once per external period tick. One counter wrap is one PWM period. The stored level is refreshed only at the wrap, so a period is never torn.

Around the proportional core sits a small mode machine. After reset, after each wake and after each restart, the fan is forced fully on for a fixed number of PWM periods so that it spins up from a standstill. When both codes sit under a programmable sleep level, the fan is switched off. It comes back when either code climbs past that level plus a fixed hysteresis. A sleep level of zero turns sleep off. A very low primary code shuts the whole block down, whatever the secondary code is. The block restarts only when the primary code rises past a higher restart level. Separately, an active-low fault flag reports an overtemperature on the primary code.

Top module: `fan_pwm_ctl`

## Requirements
- R1: The duty cycle is set by the larger of `temp_a` and `temp_b`, so control passes from one code to the other when they cross.
- R2: With m the larger code, the duty level is 0 for m <= 77, 256 for m >= 179, and floor((m-77)*256/102) in between. In run mode `fan_out` is high in the samples where the 8-bit period counter is below the level, which gives level/256 duty.
- R3: When m >= 179, `fan_out` stays high for the whole period. This includes codes above the fault threshold.
- R4: `fault_n` goes low one clock after `temp_a` > 196 is sampled, and returns high one clock after `temp_a` <= 196 is sampled.
- R5: From run mode, with `sleep_lvl` nonzero and both codes below `sleep_lvl`, the block sleeps on the next clock and `fan_out` is held low.
- R6: A sleeping block wakes when either code is strictly above `sleep_lvl` + 28. A code equal to that sum does not wake it.
- R7: With `sleep_lvl` = 0 the block never sleeps, so a change in the codes reaches the output within two periods, without a startup interval.
- R8: After reset, after a wake and after a restart, `fan_out` is high for exactly 64 periods of 256 ticks. Proportional control then begins with a freshly loaded level. During reset, `fan_out` is high and `fault_n` is high.
- R9: `temp_a` < 28 shuts the block down on the next clock: `fan_out` low and `fault_n` high, whatever `temp_b` is. The block stays off until `temp_a` > 102, then restarts with the startup interval.
- R10: The duty level is loaded only on the tick that wraps the period counter from 255 to 0. An input change within a period does not alter the rest of that period.
- R11: The period counter advances only on clocks where `pwm_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_tick | input | 1 | One-clock pulse advancing the period counter |
| temp_a | input | 8 | Primary control code (sensor) |
| temp_b | input | 8 | Secondary control code |
| sleep_lvl | input | 8 | Sleep level code, 0 disables sleep |
| fan_out | output | 1 | PWM drive to the fan switch, active high |
| fault_n | output | 1 | Overtemperature flag, active low |

## Verification
A wrong period counter or a stale duty level shows up as a wrong count of high samples within one 256-tick period, and the error is visible within two periods of the input change. A wrong mode shows up as a forced-high stretch of the wrong length, or as a sleeping or off output that stays low when it should run. The forced-high stretch is measured to the exact tick against 64 x 256 plus the expected level. A wrong fault register shows up one clock after the primary code crosses 196.

// File: rtl/fan_pkg.sv
package fan_pkg;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_START = 2'd1,
        MD_RUN   = 2'd2,
        MD_SLEEP = 2'd3
    } mode_e;

    // Comparator results handed from the level comparators to the mode machine
    typedef struct packed {
        logic off_req;    // primary code under the shutdown level
        logic on_req;     // primary code over the restart level
        logic sleep_req;  // both codes under a nonzero sleep level
        logic wake_req;   // either code over sleep level plus hysteresis
        logic over_temp;  // primary code over the fault level
    } cond_t;

    // Linear window: lo maps to 0, hi and above map to full
    function automatic int unsigned level_of(input int unsigned m,
                                             input int unsigned lo,
                                             input int unsigned hi,
                                             input int unsigned full);
        if (m <= lo)
            return 0;
        else if (m >= hi)
            return full;
        else
            return ((m - lo) * full) / (hi - lo);
    endfunction

endpackage

// File: rtl/fan_duty_calc.sv
module fan_duty_calc #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned WIN_LO = 77,
    parameter int unsigned WIN_HI = 179
) (
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic [CNT_W:0]    level
);
    localparam int unsigned FULL  = 1 << CNT_W;
    localparam int unsigned LVL_W = CNT_W + 1;

    logic [CODE_W-1:0] hi_code;

    always_comb begin
        hi_code = (code_a > code_b) ? code_a : code_b;
        level   = LVL_W'(fan_pkg::level_of(32'(hi_code), WIN_LO, WIN_HI, FULL));
    end

endmodule

// File: rtl/fan_level_cmp.sv
module fan_level_cmp #(
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned OFF_LVL = 28,
    parameter int unsigned ON_LVL  = 102,
    parameter int unsigned OT_LVL  = 196,
    parameter int unsigned HYST    = 28
) (
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic [CODE_W-1:0] slp,
    output fan_pkg::cond_t    cond
);
    localparam int unsigned EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] wake_thr;

    always_comb begin
        wake_thr       = {1'b0, slp} + EXT_W'(HYST);
        cond.off_req   = code_a < CODE_W'(OFF_LVL);
        cond.on_req    = code_a > CODE_W'(ON_LVL);
        cond.over_temp = code_a > CODE_W'(OT_LVL);
        cond.sleep_req = (slp != '0) && (code_a < slp) && (code_b < slp);
        cond.wake_req  = ({1'b0, code_a} > wake_thr) || ({1'b0, code_b} > wake_thr);
    end

endmodule

// File: rtl/fan_pwm_timebase.sv
module fan_pwm_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign wrap = tick && (cnt == {CNT_W{1'b1}});

endmodule

// File: rtl/fan_mode_ctrl.sv
module fan_mode_ctrl #(
    parameter int unsigned START_PERIODS = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  fan_pkg::cond_t cond,
    input  logic           wrap,
    output fan_pkg::mode_e mode,
    output logic           start_clr,
    output logic           fault_n
);
    import fan_pkg::*;

    localparam int unsigned SC_W = (START_PERIODS > 1) ? $clog2(START_PERIODS) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(START_PERIODS - 1);

    mode_e           mode_d;
    logic [SC_W-1:0] scnt;

    always_comb begin
        mode_d = mode;
        if (cond.off_req) begin
            mode_d = MD_OFF;
        end else begin
            unique case (mode)
                MD_OFF:   if (cond.on_req)               mode_d = MD_START;
                MD_START: if (wrap && scnt == SC_LAST)   mode_d = MD_RUN;
                MD_RUN:   if (cond.sleep_req)            mode_d = MD_SLEEP;
                MD_SLEEP: if (cond.wake_req)             mode_d = MD_START;
                default:                                 mode_d = MD_OFF;
            endcase
        end
        start_clr = (mode_d == MD_START) && (mode != MD_START);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MD_START;
            scnt    <= '0;
            fault_n <= 1'b1;
        end else begin
            mode    <= mode_d;
            fault_n <= !cond.over_temp;
            if (start_clr)
                scnt <= '0;
            else if (mode == MD_START && wrap)
                scnt <= scnt + 1'b1;
        end
    end

endmodule

// File: rtl/fan_pwm_ctl.sv
module fan_pwm_ctl #(
    parameter int unsigned CODE_W        = 8,
    parameter int unsigned CNT_W         = 8,
    parameter int unsigned WIN_LO        = 77,
    parameter int unsigned WIN_HI        = 179,
    parameter int unsigned OT_LVL        = 196,
    parameter int unsigned OFF_LVL       = 28,
    parameter int unsigned ON_LVL        = 102,
    parameter int unsigned HYST          = 28,
    parameter int unsigned START_PERIODS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_tick,
    input  logic [CODE_W-1:0] temp_a,
    input  logic [CODE_W-1:0] temp_b,
    input  logic [CODE_W-1:0] sleep_lvl,
    output logic              fan_out,
    output logic              fault_n
);
    import fan_pkg::*;

    localparam int unsigned LVL_W = CNT_W + 1;

    cond_t            cond;
    mode_e            mode;
    logic             start_clr;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] duty_q;

    fan_duty_calc #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_duty (
        .code_a(temp_a), .code_b(temp_b), .level(level)
    );

    fan_level_cmp #(
        .CODE_W(CODE_W), .OFF_LVL(OFF_LVL), .ON_LVL(ON_LVL),
        .OT_LVL(OT_LVL), .HYST(HYST)
    ) u_cmp (
        .code_a(temp_a), .code_b(temp_b), .slp(sleep_lvl), .cond(cond)
    );

    fan_pwm_timebase #(
        .CNT_W(CNT_W)
    ) u_tb (
        .clk(clk), .rst(rst), .tick(pwm_tick), .clear(start_clr),
        .cnt(cnt), .wrap(wrap)
    );

    fan_mode_ctrl #(
        .START_PERIODS(START_PERIODS)
    ) u_mode (
        .clk(clk), .rst(rst), .cond(cond), .wrap(wrap),
        .mode(mode), .start_clr(start_clr), .fault_n(fault_n)
    );

    // Level is latched at the period wrap only
    always_ff @(posedge clk) begin
        if (rst)
            duty_q <= '0;
        else if (wrap)
            duty_q <= level;
    end

    always_comb begin
        unique case (mode)
            MD_START: fan_out = 1'b1;
            MD_RUN:   fan_out = {1'b0, cnt} < duty_q;
            default:  fan_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/fan_pwm_ctl_chk.sv
module fan_pwm_ctl_chk #(
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned OT_LVL  = 196,
    parameter int unsigned OFF_LVL = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_tick,
    input logic [CODE_W-1:0] temp_a,
    input logic [CODE_W-1:0] temp_b,
    input logic [CODE_W-1:0] sleep_lvl,
    input logic              fan_out,
    input logic              fault_n,
    input fan_pkg::mode_e    mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W:0]    duty_q
);
    import fan_pkg::*;

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
        (temp_a > CODE_W'(OT_LVL)) |=> !fault_n);                               // R4
    AST_FAULT_CLR: assert property (@(posedge clk) disable iff (rst)
        (temp_a <= CODE_W'(OT_LVL)) |=> fault_n);                               // R4
    AST_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        (temp_a < CODE_W'(OFF_LVL)) |=> (!fan_out && mode == MD_OFF));          // R9
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(pwm_tick && cnt == {CNT_W{1'b1}}) |=> $stable(duty_q));               // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pwm_tick |=> ($stable(cnt) || cnt == '0));                             // R11
    AST_NO_SLEEP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sleep_lvl == '0 && mode != MD_SLEEP) |=> mode != MD_SLEEP);            // R7
    AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RUN && !(temp_a < sleep_lvl && temp_b < sleep_lvl)) |=> mode != MD_SLEEP); // R5
    AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RUN && duty_q[CNT_W]) |-> fan_out);                         // R3

endmodule

bind fan_pwm_ctl fan_pwm_ctl_chk #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .OT_LVL(OT_LVL), .OFF_LVL(OFF_LVL)
) u_chk (
    .clk(clk), .rst(rst), .pwm_tick(pwm_tick), .temp_a(temp_a),
    .temp_b(temp_b), .sleep_lvl(sleep_lvl), .fan_out(fan_out),
    .fault_n(fault_n), .mode(mode), .cnt(cnt), .duty_q(duty_q)
);

// File: tb/fan_pwm_ctl_tb.sv
module fan_pwm_ctl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_tick = 1'b1;
    logic [7:0] temp_a = 8'd128;
    logic [7:0] temp_b = 8'd0;
    logic [7:0] sleep_lvl = 8'd0;
    logic       fan_out;
    logic       fault_n;

    int checks = 0;
    int fails  = 0;

    localparam int START_LEN = 64 * 256;

    always #2 clk = ~clk;

    fan_pwm_ctl u_dut (
        .clk(clk), .rst(rst), .pwm_tick(pwm_tick), .temp_a(temp_a),
        .temp_b(temp_b), .sleep_lvl(sleep_lvl), .fan_out(fan_out),
        .fault_n(fault_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_level(input int m);
        if (m <= 77) return 0;
        if (m >= 179) return 256;
        return ((m - 77) * 256) / 102;
    endfunction

    // Count high samples over len negedges, starting at the current one
    task automatic period_highs(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            if (fan_out) n++;
            @(negedge clk);
        end
    endtask

    // Length of the high stretch beginning at the current negedge
    task automatic high_run(output int n);
        n = 0;
        while (fan_out && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_fall();
        logic prev;
        prev = fan_out;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (prev && !fan_out) return;
            prev = fan_out;
        end
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        check("R8 reset out", int'(fan_out), 1);
        check("R8 reset fault_n", int'(fault_n), 1);
        rst = 1'b0;
        high_run(n);
        check("R8/R2 startup then level 128", n, START_LEN + 128);
    endtask

    task automatic t_duty(input string req, input logic [7:0] a, input logic [7:0] b);
        int n;
        temp_a = a;
        temp_b = b;
        repeat (512) @(negedge clk);
        period_highs(256, n);
        check(req, n, exp_level((a > b) ? int'(a) : int'(b)));
    endtask

    task automatic t_boundary();
        int n;
        temp_a = 8'd128; temp_b = 8'd0;
        repeat (512) @(negedge clk);
        wait_fall();
        temp_a = 8'd179;
        period_highs(128, n);
        check("R10 rest of period keeps old level", n, 0);
        period_highs(256, n);
        check("R10 next period takes new level", n, 256);
    endtask

    task automatic t_tick();
        int n;
        temp_a = 8'd128;
        repeat (512) @(negedge clk);
        wait_fall();
        while (!fan_out) @(negedge clk);
        pwm_tick = 1'b0;
        period_highs(300, n);
        check("R11 counter frozen without tick", n, 300);
        pwm_tick = 1'b1;
        high_run(n);
        check("R11 remaining high after resume", n, 128);
    endtask

    task automatic t_fault();
        int n;
        temp_a = 8'd197; temp_b = 8'd0;
        @(negedge clk);
        check("R4 fault asserts one clock later", int'(fault_n), 0);
        repeat (512) @(negedge clk);
        period_highs(256, n);
        check("R3 full on during fault", n, 256);
        temp_a = 8'd196;
        @(negedge clk);
        check("R4 fault clears at threshold", int'(fault_n), 1);
    endtask

    task automatic t_sleep();
        int n;
        sleep_lvl = 8'd100;
        temp_a = 8'd110; temp_b = 8'd90;
        repeat (512) @(negedge clk);
        period_highs(256, n);
        check("R5 one code above level, no sleep", n, exp_level(110));
        temp_a = 8'd90;
        @(negedge clk);
        period_highs(512, n);
        check("R5 both below level sleeps", n, 0);
        temp_b = 8'd128;
        @(negedge clk);
        period_highs(512, n);
        check("R6 equal to wake sum stays asleep", n, 0);
        temp_b = 8'd129;
        @(negedge clk);
        high_run(n);
        check("R6/R8 wake startup then level", n, START_LEN + exp_level(129));
        sleep_lvl = 8'd0;
    endtask

    task automatic t_nosleep();
        int n;
        sleep_lvl = 8'd0;
        temp_a = 8'd30; temp_b = 8'd30;
        repeat (600) @(negedge clk);
        temp_a = 8'd128;
        repeat (512) @(negedge clk);
        period_highs(256, n);
        check("R7 zero level, no startup after change", n, 128);
    endtask

    task automatic t_shutdown();
        int n;
        temp_a = 8'd128; temp_b = 8'd200;
        repeat (300) @(negedge clk);
        temp_a = 8'd20;
        @(negedge clk);
        check("R9 out low after shutdown", int'(fan_out), 0);
        check("R9 fault_n high in shutdown", int'(fault_n), 1);
        period_highs(512, n);
        check("R9 off despite high secondary", n, 0);
        temp_a = 8'd60;
        period_highs(512, n);
        check("R9 stays off between levels", n, 0);
        temp_a = 8'd102;
        period_highs(300, n);
        check("R9 restart level is exclusive", n, 0);
        temp_b = 8'd0;
        temp_a = 8'd103;
        @(negedge clk);
        high_run(n);
        check("R9/R8 restart startup then level", n, START_LEN + exp_level(103));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_duty("R2 level at 128", 8'd128, 8'd0);
        t_duty("R1 secondary controls", 8'd100, 8'd128);
        t_duty("R1 larger code 150", 8'd60, 8'd150);
        t_duty("R2 window floor gives zero", 8'd77, 8'd77);
        t_duty("R3 top of window full on", 8'd179, 8'd0);
        t_duty("R3 above window full on", 8'd190, 8'd10);
        t_boundary();
        t_tick();
        t_fault();
        t_nosleep();
        t_sleep();
        t_shutdown();
        summary();
        $finish;
    end

endmodule